// File: doc/BRIEF.md
# Streaming Packet Receive Checker

This block sits on the receive side of a word-wide packet stream and checks what arrives. It drives the read request back to the source. Each returned word carries a valid strobe and start and end markers. The first word of every packet holds the packet's intended length. The checker counts the words that actually arrive and compares the count with that length when the end marker comes. It also checks that payload words form an incrementing sequence and that start and end markers come in a legal order. It keeps a running total of good packets and raises one sticky error flag on any violation.

Two parameters change how reads are requested. In streaming mode every read is gated by the source's data-available signal. In priority mode that signal is needed only to start a packet: once a packet is open, reads continue regardless of it. A run-time input can also thin the read requests with a free-running pseudo-random sequence. This puts gaps inside packets and exercises the source's back-pressure path.

Top module: `pkt_rx_checker`

## Requirements
- R1: After a cycle with `rst_n` low at a clock edge, `err_flag_o` is 0, `pkt_count_o` is 0 and no packet is open.
- R2: Bits [15:0] of a start-of-packet word give the packet's length in words, counting the header word and the last word. On an end-of-packet word, a received word count different from that length sets `err_flag_o` and leaves `pkt_count_o` unchanged.
- R3: `pkt_count_o` increases by exactly one on each end-of-packet word whose packet length matches, and does not change on any other cycle.
- R4: A word with both `sop_i` and `eop_i` high is a one-word packet. It is counted when its length field is 1 and sets `err_flag_o` for any other value.
- R5: Word 1 of a packet (the word after the header) sets the starting value of the payload sequence. Every later word must equal the previous word plus one, modulo 2^DATA_W. A mismatch sets `err_flag_o` but does not stop the packet from being counted.
- R6: A valid word with `sop_i` low while no packet is open sets `err_flag_o` and is discarded without opening a packet.
- R7: A start-of-packet word while a packet is open sets `err_flag_o`. The open packet is dropped without being counted, and the new packet starts from that word.
- R8: Once set, `err_flag_o` stays 1 until reset, while packet counting continues.
- R9: Cycles with `vld_i` low have no effect, whatever `sop_i`, `eop_i` and `data_i` hold.
- R10: With `PRIO_MODE` = 0 and `gap_en_i` = 0, `rd_en_o` equals `dav_i` in every cycle.
- R11: With `PRIO_MODE` = 1, `rd_en_o` is held high while a packet is open, from the cycle after its start-of-packet word until its end-of-packet word is taken, whatever `dav_i` is. Outside a packet it follows the same rule as R10.
- R12: When `gap_en_i` = 1, `rd_en_o` is the R10/R11 value ANDed with bit 0 of a 16-bit LFSR. The LFSR loads 16'hACE1 in reset and then, on every clock, shifts left and takes bit15^bit13^bit12^bit10 into bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dav_i | input | 1 | Source has data available |
| gap_en_i | input | 1 | Enables pseudo-random read gaps |
| rd_en_o | output | 1 | Read request to the source |
| vld_i | input | 1 | Returned word is valid |
| sop_i | input | 1 | Start-of-packet marker |
| eop_i | input | 1 | End-of-packet marker |
| data_i | input | DATA_W | Returned word |
| pkt_count_o | output | CNT_W | Running count of correctly sized packets |
| err_flag_o | output | 1 | Sticky error flag |

## Verification
The length check is run with packets that match their length, that run one word long and that stop two words short. These separate an off-by-one in the counter from a missing comparison. Pattern breaks are placed on the first checked payload word, on a middle word and on the last word, and one stream wraps through all-ones. Together these show whether the sequence origin, the carry and the end-of-packet beat are handled. Marker faults (an orphan word, a restart inside a packet, and one-word packets with good and bad lengths) are each run from reset, and then followed by good traffic to show that the flag is sticky and that counting goes on. The read-request tests compare streaming and priority instances under the same stimulus, and check the gap mode against an LFSR model stepped beside the design.

// File: rtl/pkt_rx_pkg.sv
// Package pkt_rx_pkg
// Shared constants for the packet receive checker: the width of the
// length field and the LFSR seed and width. Assumes the length field
// sits in the low bits of the header word.
package pkt_rx_pkg;
    localparam int LEN_W      = 16;
    localparam int LFSR_W     = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/pkt_rx_lfsr.sv
// Module pkt_rx_lfsr
// Free-running 16-bit maximal-length Fibonacci LFSR (taps 16,14,13,11).
// Loads the non-zero package seed in reset and steps once per clock.
// Assumes the seed is non-zero, so the state never reaches all-zero.
module pkt_rx_lfsr
    import pkt_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] state_o
);
    logic [LFSR_W-1:0] lfsr_q;
    logic              fb;

    // Feedback bit from the four tap positions.
    always_comb fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    // Load seed in reset, otherwise shift left and insert feedback.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= LFSR_SEED;
        else        lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
    end

    assign state_o = lfsr_q;

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R12
endmodule

// File: rtl/pkt_rx_frame.sv
// Module pkt_rx_frame
// Checks the received word stream: marker order, length against the
// header field, and the incrementing payload sequence. Keeps the good
// packet counter and the sticky error flag.
// Assumes only words with vld_i high carry meaning.
module pkt_rx_frame
    import pkt_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic              sop_i,
    input  logic              eop_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              open_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              err_o
);
    logic              open_q, open_n;
    logic [LEN_W-1:0]  len_q, len_n;
    logic [LEN_W-1:0]  wcnt_q, wcnt_n;
    logic [DATA_W-1:0] prev_q, prev_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              err_q, err_n;
    logic [LEN_W-1:0]  wnext;

    // Next-state decode for one received word.
    always_comb begin
        open_n = open_q;
        len_n  = len_q;
        wcnt_n = wcnt_q;
        prev_n = prev_q;
        cnt_n  = cnt_q;
        err_n  = err_q;
        wnext  = wcnt_q + 1'b1;
        if (vld_i) begin
            if (sop_i) begin
                if (open_q) err_n = 1'b1;
                len_n  = data_i[LEN_W-1:0];
                wcnt_n = {{(LEN_W-1){1'b0}}, 1'b1};
                if (eop_i) begin
                    open_n = 1'b0;
                    if (data_i[LEN_W-1:0] == {{(LEN_W-1){1'b0}}, 1'b1})
                        cnt_n = cnt_q + 1'b1;
                    else
                        err_n = 1'b1;
                end else begin
                    open_n = 1'b1;
                end
            end else if (!open_q) begin
                err_n = 1'b1;
            end else begin
                wcnt_n = wnext;
                prev_n = data_i;
                if (wcnt_q >= LEN_W'(2) && data_i != prev_q + 1'b1)
                    err_n = 1'b1;
                if (eop_i) begin
                    open_n = 1'b0;
                    if (wnext == len_q) cnt_n = cnt_q + 1'b1;
                    else                err_n = 1'b1;
                end
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            len_q  <= '0;
            wcnt_q <= '0;
            prev_q <= '0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            open_q <= open_n;
            len_q  <= len_n;
            wcnt_q <= wcnt_n;
            prev_q <= prev_n;
            cnt_q  <= cnt_n;
            err_q  <= err_n;
        end
    end

    assign open_o = open_q;
    assign cnt_o  = cnt_q;
    assign err_o  = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R8
    AST_CNT_EOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_i && eop_i) |=> $stable(cnt_q)); // R3
    AST_ORPHAN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !sop_i && !open_q) |=> (err_q && !open_q)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> ($stable(open_q) && $stable(wcnt_q))); // R9
endmodule

// File: rtl/pkt_rx_checker.sv
// Module pkt_rx_checker (top)
// Receive-side checker for a packet stream. Generates the read request
// from data-available, the priority mode and optional LFSR gaps, and
// passes returned words to the frame checker.
// Assumes the source answers a read with a valid word one cycle later.
module pkt_rx_checker
    import pkt_rx_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter bit PRIO_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dav_i,
    input  logic              gap_en_i,
    output logic              rd_en_o,
    input  logic              vld_i,
    input  logic              sop_i,
    input  logic              eop_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CNT_W-1:0]  pkt_count_o,
    output logic              err_flag_o
);
    logic [LFSR_W-1:0] lfsr;
    logic              pkt_open;
    logic              allow;
    logic              gap_ok;

    pkt_rx_lfsr u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (lfsr)
    );

    pkt_rx_frame #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (vld_i),
        .sop_i  (sop_i),
        .eop_i  (eop_i),
        .data_i (data_i),
        .open_o (pkt_open),
        .cnt_o  (pkt_count_o),
        .err_o  (err_flag_o)
    );

    generate
        if (PRIO_MODE) begin : g_prio
            // Data-available only matters to start a packet.
            always_comb allow = pkt_open | dav_i;
        end else begin : g_stream
            // Data-available gates every read.
            always_comb allow = dav_i;
            AST_RDEN_DAV: assert property (@(posedge clk) disable iff (!rst_n)
                !dav_i |-> !rd_en_o); // R10
        end
    endgenerate

    // Optional pseudo-random thinning of read requests.
    always_comb gap_ok = !gap_en_i | lfsr[0];

    assign rd_en_o = allow & gap_ok;

    AST_GAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_en_i && !lfsr[0]) |-> !rd_en_o); // R12
endmodule

// File: tb/tb_pkt_rx_checker.sv
`timescale 1ns/1ps
module tb_pkt_rx_checker;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dav = 1'b0, gap_en = 1'b0;
    logic          vld = 1'b0, sop = 1'b0, eop = 1'b0;
    logic [DW-1:0] data = '0;
    logic          rd_en, rd_en_p, err, err_p;
    logic [CW-1:0] cnt, cnt_p;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pkt_rx_checker #(.DATA_W(DW), .CNT_W(CW), .PRIO_MODE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .dav_i(dav), .gap_en_i(gap_en), .rd_en_o(rd_en),
        .vld_i(vld), .sop_i(sop), .eop_i(eop), .data_i(data),
        .pkt_count_o(cnt), .err_flag_o(err));

    pkt_rx_checker #(.DATA_W(DW), .CNT_W(CW), .PRIO_MODE(1'b1)) dut_prio (
        .clk(clk), .rst_n(rst_n), .dav_i(dav), .gap_en_i(gap_en), .rd_en_o(rd_en_p),
        .vld_i(vld), .sop_i(sop), .eop_i(eop), .data_i(data),
        .pkt_count_o(cnt_p), .err_flag_o(err_p));

    // LFSR reference built from R12.
    logic [15:0] ref_lfsr;
    always @(posedge clk) begin
        if (!rst_n) ref_lfsr <= 16'hACE1;
        else ref_lfsr <= {ref_lfsr[14:0], ref_lfsr[15]^ref_lfsr[13]^ref_lfsr[12]^ref_lfsr[10]};
    end

    typedef struct packed {
        logic [15:0] len;
        logic [7:0]  nw;
        logic [7:0]  brk;
        logic [31:0] base;
        logic        xerr;
        logic [15:0] xcnt;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{16'd4, 8'd4, 8'd0, 32'h0000_0100, 1'b0, 16'd1}, // R2 R3 match
        '{16'd6, 8'd6, 8'd0, 32'hFFFF_FFFE, 1'b0, 16'd1}, // R5 wrap
        '{16'd4, 8'd5, 8'd0, 32'h0000_0010, 1'b1, 16'd0}, // R2 long
        '{16'd5, 8'd3, 8'd0, 32'h0000_0010, 1'b1, 16'd0}, // R2 short
        '{16'd5, 8'd5, 8'd3, 32'h0000_0200, 1'b1, 16'd1}, // R5 middle
        '{16'd2, 8'd2, 8'd0, 32'h1234_5678, 1'b0, 16'd1}, // R5 no check
        '{16'd8, 8'd8, 8'd7, 32'h0000_0000, 1'b1, 16'd1}, // R5 last
        '{16'd3, 8'd3, 8'd2, 32'h0000_0040, 1'b1, 16'd1}  // R5 first checked
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vld = 1'b0; sop = 1'b1; eop = 1'b1; data = 32'hDEAD_BEEF;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vld = 1'b0; sop = 1'b0; eop = 1'b0; dav = 1'b0; gap_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic word(input logic s, input logic e, input logic [31:0] d);
        @(negedge clk);
        vld = 1'b1; sop = s; eop = e; data = d;
    endtask

    // Header plus nw-1 payload words; brk>0 corrupts that word index.
    task automatic packet(input logic [15:0] len, input int nw, input int brk,
                          input logic [31:0] base, input bit gaps);
        word(1'b1, nw == 1, {16'hA5A5, len});
        for (int k = 1; k < nw; k++) begin
            if (gaps) idle(1);
            word(1'b0, k == nw - 1, (base + 32'(k - 1)) ^ ((k == brk) ? 32'h10 : 32'h0));
        end
        idle(1);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 err", {31'b0, err}, 0);
        check("R1 count", {16'b0, cnt}, 0);
        check("R1 prio rd_en idle", {31'b0, rd_en_p}, 0);

        // Table of single packets, each from reset; odd entries with gaps (R9).
        for (int v = 0; v < NV; v++) begin
            do_reset();
            packet(VEC[v].len, int'(VEC[v].nw), int'(VEC[v].brk), VEC[v].base, v[0]);
            check($sformatf("R2/R5 vec%0d err", v), {31'b0, err}, {31'b0, VEC[v].xerr});
            check($sformatf("R3 vec%0d count", v), {16'b0, cnt}, {16'b0, VEC[v].xcnt});
        end

        // R8: sticky after error, counting continues.
        packet(16'd3, 3, 0, 32'h50, 1'b0);
        check("R8 err sticky", {31'b0, err}, 1);
        check("R8 count continues", {16'b0, cnt}, 2);

        // R3: back-to-back good packets.
        do_reset();
        packet(16'd3, 3, 0, 32'h1, 1'b0);
        packet(16'd4, 4, 0, 32'h9, 1'b0);
        packet(16'd2, 2, 0, 32'h7, 1'b1);
        check("R3 three packets", {16'b0, cnt}, 3);
        check("R3 no error", {31'b0, err}, 0);

        // R4: one-word packets.
        do_reset();
        packet(16'd1, 1, 0, 32'h0, 1'b0);
        check("R4 len1 count", {16'b0, cnt}, 1);
        check("R4 len1 err", {31'b0, err}, 0);
        do_reset();
        packet(16'd2, 1, 0, 32'h0, 1'b0);
        check("R4 len2 err", {31'b0, err}, 1);
        check("R4 len2 count", {16'b0, cnt}, 0);

        // R6: orphan word, then a good packet.
        do_reset();
        word(1'b0, 1'b1, 32'h3);
        idle(1);
        check("R6 orphan err", {31'b0, err}, 1);
        packet(16'd2, 2, 0, 32'h3, 1'b0);
        check("R6 orphan not opened", {16'b0, cnt}, 1);

        // R7: restart inside a packet.
        do_reset();
        word(1'b1, 1'b0, {16'h0, 16'd4});
        word(1'b0, 1'b0, 32'h20);
        packet(16'd3, 3, 0, 32'h60, 1'b0);
        check("R7 restart err", {31'b0, err}, 1);
        check("R7 restart count", {16'b0, cnt}, 1);

        // R10 / R11: read request in streaming and priority modes.
        do_reset();
        @(negedge clk); dav = 1'b1;
        #1 check("R10 rd_en dav=1", {31'b0, rd_en}, 1);
        dav = 1'b0;
        #1 check("R10 rd_en dav=0", {31'b0, rd_en}, 0);
        word(1'b1, 1'b0, {16'h0, 16'd3});
        @(negedge clk); vld = 1'b0;
        check("R11 prio rd_en open dav=0", {31'b0, rd_en_p}, 1);
        check("R10 stream rd_en dav=0", {31'b0, rd_en}, 0);
        word(1'b0, 1'b0, 32'h5);
        word(1'b0, 1'b1, 32'h6);
        idle(1);
        check("R11 prio rd_en closed", {31'b0, rd_en_p}, 0);
        check("R11 prio count", {16'b0, cnt_p}, 1);

        // R12: gap mode follows LFSR bit 0.
        do_reset();
        @(negedge clk); gap_en = 1'b1; dav = 1'b1;
        begin
            int mism = 0, lows = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (rd_en !== ref_lfsr[0]) mism++;
                if (!rd_en) lows++;
            end
            check("R12 rd_en vs lfsr", mism, 0);
            check("R12 gaps present", {31'b0, lows > 0}, 1);
        end
        dav = 1'b0;
        #1 check("R12 dav low blocks", {31'b0, rd_en}, 0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule